// File: doc/BRIEF.md
# Single-Path Circuit Switch Controller

This block controls a 4x4 blocking circuit switch. The switching element can carry only one route at a time, between any input and any output. Each input can ask for a route to a chosen output, and the owner of an open route can ask to close it. A route is opened only when the switch is empty. Requests that lose arbitration or that arrive while a route is open get a reject pulse, and the requester backs off and tries again later.

The controller keeps the connection state, a source and a destination. From that state it drives a registered enable for each output and a select field that names the source input. It also raises a bend flag when the route turns, meaning the input and output indices differ. With no route open every enable is low, so the element draws no power. When several inputs ask in the same cycle, a round-robin arbiter chooses one of them. An active flag and the current pair are brought out so the state can be observed.

Top module: `xbar_path_ctrl`

## Requirements
- R1: After a synchronous reset, `active`, `grant`, `reject`, `out_en`, `out_sel`, `bend`, `cur_src` and `cur_dst` are all zero, and the round-robin pointer is at input 0.
- R2: When the switch is idle and exactly one input raises `setup_req`, that input's `grant` bit pulses in the next cycle. In the same cycle `active` rises and `cur_src`/`cur_dst` show the input index and the requested output. The requested output is the field `setup_dst[i*2 +: 2]` for input i.
- R3: While `active` is high, every `setup_req` is answered with a `reject` pulse on the same bit in the next cycle, and no grant is given. This holds even when the requested ports are disjoint from the open route, and the connection state does not change.
- R4: When the switch is idle and several inputs request in the same cycle, the winner is the first requester found by searching upward from the round-robin pointer and wrapping around. Only the winner gets `grant`; every other requester gets `reject` in that same cycle. After a grant the pointer moves to the winner index plus one, modulo 4.
- R5: A `teardown_req` from the owning input (`cur_src`) while `active` is high closes the route. In the next cycle `active`, all of `out_en`, `bend`, `cur_src` and `cur_dst` are zero.
- R6: A `teardown_req` from any input other than the owner, or any teardown while idle, is ignored. The route and all outputs stay as they were.
- R7: While a route is open, `out_en` is one-hot at bit `cur_dst`. The field `out_sel[o*2 +: 2]` holds `cur_src` for o = `cur_dst`, and every other field is zero. `bend` is high exactly when `cur_src` differs from `cur_dst`.
- R8: `grant` and `reject` are single-cycle pulses, given only in the cycle after a matching `setup_req`, and never both on the same bit.
- R9: Every one of the 16 input/output pairs can be opened and then closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_req | input | 4 | Per-input route request |
| setup_dst | input | 8 | Requested output for each input, 2 bits per input |
| teardown_req | input | 4 | Per-input release request |
| grant | output | 4 | Per-input grant pulse |
| reject | output | 4 | Per-input reject pulse |
| active | output | 1 | A route is open |
| cur_src | output | 2 | Input of the open route, zero when idle |
| cur_dst | output | 2 | Output of the open route, zero when idle |
| out_en | output | 4 | Per-output enable of the switching element |
| out_sel | output | 8 | Per-output source-input select, 2 bits per output |
| bend | output | 1 | The open route turns (input index differs from output index) |

## Verification
A connection state that is wrong inside the block shows at the ports one cycle after the edge that corrupted it. It appears as a second enable bit, as a select field that does not match `cur_src`, or as an enable left high after a valid teardown. A busy flag that is wrong shows in the response to the next request: a grant where a reject is due, or a double grant. A round-robin pointer that is wrong stays hidden until several inputs contend, and then it picks the wrong winner on the first contended request.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Step an index forward by one, wrapping at n.
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] req,
  input  logic [IDX_W-1:0]   ptr,
  output logic               any,
  output logic [IDX_W-1:0]   win
);
  logic [IDX_W-1:0] cand;

  // Search upward from the pointer and wrap; the first requester wins.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    cand = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      cand = IDX_W'((int'(ptr) + k) % N_PORTS);
      if (!any && req[cand]) begin
        any = 1'b1;
        win = cand;
      end
    end
  end
endmodule

// File: rtl/xbar_drive.sv
module xbar_drive #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy_d,
  input  logic [IDX_W-1:0]         src_d,
  input  logic [IDX_W-1:0]         dst_d,
  output logic [N_PORTS-1:0]       out_en,
  output logic [N_PORTS*IDX_W-1:0] out_sel,
  output logic                     bend
);
  // Each output lane is registered straight from the next connection state,
  // so its enable lines up with the active flag.
  for (genvar o = 0; o < N_PORTS; o++) begin : g_lane
    logic hit;
    assign hit = busy_d && (dst_d == IDX_W'(o));
    always_ff @(posedge clk) begin
      if (rst) begin
        out_en[o]                 <= 1'b0;
        out_sel[o*IDX_W +: IDX_W] <= '0;
      end else begin
        out_en[o]                 <= hit;
        out_sel[o*IDX_W +: IDX_W] <= hit ? src_d : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bend <= 1'b0;
    else     bend <= busy_d && (src_d != dst_d);
  end
endmodule

// File: rtl/xbar_path_ctrl.sv
module xbar_path_ctrl #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PORTS-1:0]       setup_req,
  input  logic [N_PORTS*IDX_W-1:0] setup_dst,
  input  logic [N_PORTS-1:0]       teardown_req,
  output logic [N_PORTS-1:0]       grant,
  output logic [N_PORTS-1:0]       reject,
  output logic                     active,
  output logic [IDX_W-1:0]         cur_src,
  output logic [IDX_W-1:0]         cur_dst,
  output logic [N_PORTS-1:0]       out_en,
  output logic [N_PORTS*IDX_W-1:0] out_sel,
  output logic                     bend
);
  import xbar_pkg::*;

  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     src_q, src_d, dst_q, dst_d, ptr_q, ptr_d;
  logic [N_PORTS-1:0]   gnt_d, rej_d;
  logic                 arb_any;
  logic [IDX_W-1:0]     arb_win;

  xbar_rr_arb #(.N_PORTS(N_PORTS)) i_arb (
    .req (setup_req),
    .ptr (ptr_q),
    .any (arb_any),
    .win (arb_win)
  );

  always_comb begin
    busy_d = busy_q;
    src_d  = src_q;
    dst_d  = dst_q;
    ptr_d  = ptr_q;
    gnt_d  = '0;
    rej_d  = '0;
    if (busy_q) begin
      // Blocking element: every setup request fails while a route is open.
      rej_d = setup_req;
      if (teardown_req[src_q]) begin
        busy_d = 1'b0;
        src_d  = '0;
        dst_d  = '0;
      end
    end else if (arb_any) begin
      gnt_d[arb_win] = 1'b1;
      rej_d          = setup_req & ~gnt_d;
      busy_d         = 1'b1;
      src_d          = arb_win;
      dst_d          = setup_dst[int'(arb_win)*IDX_W +: IDX_W];
      ptr_d          = IDX_W'(wrap_inc(int'(arb_win), N_PORTS));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      ptr_q  <= '0;
      grant  <= '0;
      reject <= '0;
    end else begin
      busy_q <= busy_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      ptr_q  <= ptr_d;
      grant  <= gnt_d;
      reject <= rej_d;
    end
  end

  assign active  = busy_q;
  assign cur_src = src_q;
  assign cur_dst = dst_q;

  xbar_drive #(.N_PORTS(N_PORTS)) i_drive (
    .clk     (clk),
    .rst     (rst),
    .busy_d  (busy_d),
    .src_d   (src_d),
    .dst_d   (dst_d),
    .out_en  (out_en),
    .out_sel (out_sel),
    .bend    (bend)
  );
endmodule

// File: rtl/xbar_path_chk.sv
module xbar_path_chk #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_PORTS-1:0]   setup_req,
  input logic [N_PORTS-1:0]   teardown_req,
  input logic [N_PORTS-1:0]   grant,
  input logic [N_PORTS-1:0]   reject,
  input logic                 active,
  input logic [IDX_W-1:0]     cur_src,
  input logic [N_PORTS-1:0]   out_en,
  input logic                 bend
);
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_single_path_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_en) && (active == (|out_en)));

  assert_busy_rejects_R3: assert property (@(posedge clk) disable iff (rst)
    (active && (|setup_req)) |=> (grant == '0 && reject == $past(setup_req)));

  assert_owner_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (active && !teardown_req[cur_src]) |=> active);

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (active && teardown_req[cur_src]) |=> (!active && out_en == '0));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !(|setup_req) |=> (grant == '0 && reject == '0));

  assert_resp_disjoint_R8: assert property (@(posedge clk) disable iff (rst)
    (grant & reject) == '0);

  assert_bend_needs_path_R7: assert property (@(posedge clk) disable iff (rst)
    bend |-> active);
endmodule

bind xbar_path_ctrl xbar_path_chk #(.N_PORTS(N_PORTS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .setup_req    (setup_req),
  .teardown_req (teardown_req),
  .grant        (grant),
  .reject       (reject),
  .active       (active),
  .cur_src      (cur_src),
  .out_en       (out_en),
  .bend         (bend)
);

// File: tb/test_xbar_path_ctrl.sv
`timescale 1ns/1ps
module test_xbar_path_ctrl;
  localparam int N = 4;
  localparam int W = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   setup_req;
  logic [N*W-1:0] setup_dst;
  logic [N-1:0]   teardown_req;
  logic [N-1:0]   grant, reject, out_en;
  logic           active, bend;
  logic [W-1:0]   cur_src, cur_dst;
  logic [N*W-1:0] out_sel;

  int total = 0;
  int bad   = 0;

  // Reference model state
  logic         m_busy;
  logic [W-1:0] m_src, m_dst, m_ptr;
  logic [N-1:0] e_gnt, e_rej;

  always #2 clk = ~clk;

  xbar_path_ctrl #(.N_PORTS(N)) i_xbar_path_ctrl (
    .clk(clk), .rst(rst), .setup_req(setup_req), .setup_dst(setup_dst),
    .teardown_req(teardown_req), .grant(grant), .reject(reject),
    .active(active), .cur_src(cur_src), .cur_dst(cur_dst),
    .out_en(out_en), .out_sel(out_sel), .bend(bend)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rr_pick(input logic [N-1:0] r, input logic [W-1:0] p);
    for (int k = 0; k < N; k++) begin
      if (r[(int'(p) + k) % N]) return W'((int'(p) + k) % N);
    end
    return '0;
  endfunction

  function automatic logic [N*W-1:0] exp_sel();
    logic [N*W-1:0] v = '0;
    if (m_busy) v[int'(m_dst)*W +: W] = m_src;
    return v;
  endfunction

  task automatic check_outputs(input string tag);
    logic [N-1:0] een = m_busy ? (N'(1) << m_dst) : '0;
    chk(grant == e_gnt, tag, "grant", int'(grant), int'(e_gnt));
    chk(reject == e_rej, tag, "reject", int'(reject), int'(e_rej));
    chk(active == m_busy, tag, "active", int'(active), int'(m_busy));
    chk(cur_src == m_src && cur_dst == m_dst, tag, "pair",
        int'({cur_src, cur_dst}), int'({m_src, m_dst}));
    chk(out_en == een, tag, "out_en", int'(out_en), int'(een));
    chk(out_sel == exp_sel(), tag, "out_sel", int'(out_sel), int'(exp_sel()));
    chk(bend == (m_busy && m_src != m_dst), tag, "bend", int'(bend),
        int'(m_busy && m_src != m_dst));
  endtask

  // Apply one cycle of requests, update the model, check after the edge.
  task automatic step(input logic [N-1:0] s, input logic [N*W-1:0] d,
                      input logic [N-1:0] t, input string tag);
    @(negedge clk);
    setup_req = s; setup_dst = d; teardown_req = t;
    e_gnt = '0; e_rej = '0;
    if (m_busy) begin
      e_rej = s;
      if (t[m_src]) begin m_busy = 1'b0; m_src = '0; m_dst = '0; end
    end else if (s != '0) begin
      logic [W-1:0] w = rr_pick(s, m_ptr);
      e_gnt = N'(1) << w;
      e_rej = s & ~e_gnt;
      m_busy = 1'b1; m_src = w; m_dst = d[int'(w)*W +: W];
      m_ptr = W'((int'(w) + 1) % N);
    end
    @(posedge clk); #1;
    check_outputs(tag);
    @(negedge clk);
    setup_req = '0; teardown_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    rst = 1'b1; setup_req = '0; setup_dst = '0; teardown_req = '0;
    m_busy = 0; m_src = '0; m_dst = '0; m_ptr = '0; e_gnt = '0; e_rej = '0;
    repeat (3) @(posedge clk);
    #1;
    check_outputs("R1");
    @(negedge clk); rst = 1'b0;

    // R6: teardown while idle does nothing
    step('0, '0, 4'b1111, "R6");
    // R2: single request from input 2 to output 1
    step(4'b0100, 8'b00_01_00_00, '0, "R2");
    // R3: disjoint request while busy is rejected
    step(4'b1001, 8'b10_00_00_11, '0, "R3");
    // R6: teardown by non-owners
    step('0, '0, 4'b1011, "R6");
    step('0, '0, 4'b0000, "R8");
    // R3: teardown by owner plus new request in same cycle -> rejected
    step(4'b0001, 8'h00, 4'b0100, "R3");
    // R4: contention, pointer at 3 after the grant to input 2
    step(4'b1111, 8'b11_10_01_00, '0, "R4");
    step('0, '0, 4'b1000, "R5");
    step(4'b1111, 8'b00_01_10_11, '0, "R4");
    step('0, '0, 4'b0001, "R5");
    step(4'b0110, 8'b00_11_10_00, '0, "R4");
    step('0, '0, 4'b0010, "R5");

    // R9: every pair opened, with straight and turning routes (R7)
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        logic [N*W-1:0] d = '0;
        d[i*W +: W] = W'(o);
        step(N'(1) << i, d, '0, "R9");
        step('0, '0, N'(1) << i, "R9");
      end
    end

    // R8: random mix of requests and teardowns
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] s = ($urandom % 3 == 0) ? N'($urandom) : '0;
      logic [N-1:0] t = ($urandom % 4 == 0) ? N'($urandom) : '0;
      step(s, (N*W)'($urandom), t, "R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule